// File: doc/BRIEF.md
# Byte-Lane Bus Interface Controller

This block connects a processor-side request port to a byte-addressed memory bus that is 16 bits wide. The memory on that bus is organised as 16-bit words. The byte at an even address travels on the low lane and the byte at the odd address above it travels on the high lane.

Each request carries a byte address, a size (byte or word), a direction and write data. The controller turns the request into one or two bus cycles. Each cycle drives a word-aligned address, an A0 line and an active-low high-lane enable. On the memory side, the low lane is enabled when A0 is low and the high lane is enabled when the high-lane enable is asserted.

A word access at an odd address is split into two aligned cycles. For reads, the returned lanes are steered and merged into a little-endian result, and byte results are zero-extended. Requests use a valid/ready handshake, and a one-cycle done pulse marks completion.

Top module: `bytelane_bus_ctrl`

## Requirements
- R1: `bus_addr` bit 0 is always zero. The byte at an even address uses `bus_wdata`/`bus_rdata` bits 7:0, and the byte at the odd address above it uses bits 15:8.
- R2: A byte access at an even address is one bus cycle at that address with `bus_a0`=0 and `bus_bhe_n`=1.
- R3: A byte access at an odd address N is one bus cycle at N-1 with `bus_a0`=1 and `bus_bhe_n`=0.
- R4: A word access at an even address is one bus cycle at that address with `bus_a0`=0 and `bus_bhe_n`=0.
- R5: No bus cycle ever drives `bus_a0`=1 together with `bus_bhe_n`=1.
- R6: A word read at an odd address N takes two bus cycles, with `bus_a0`=0 and `bus_bhe_n`=0 in both.
  - The first cycle reads address N-1 and the second reads N+1.
  - The result carries the high lane of the first read in bits 7:0 and the low lane of the second read in bits 15:8.
- R7: A byte read returns the lane selected by address parity in `rsp_rdata` bits 7:0, with bits 15:8 zero.
- R8: A word write at an odd address N takes two bus cycles.
  - The first cycle is at N-1 with `bus_a0`=1 and `bus_bhe_n`=0, and carries data bits 7:0 on the high lane.
  - The second cycle is at N+1 with `bus_a0`=0 and `bus_bhe_n`=1, and carries data bits 15:8 on the low lane.
  - No other byte of memory changes.
- R9: Handshake timing.
  - `req_ready` is high only when no request is in progress, and it stays low during every bus cycle.
  - A request is taken when `req_valid` and `req_ready` are both high, and its first bus cycle comes in the next clock.
  - `rsp_done` is a one-cycle pulse in the clock after the final bus cycle, and `rsp_rdata` is valid with it.
- R10: Word data is little-endian: bits 7:0 are stored at byte address N and bits 15:8 at N+1.
- R11: The second cycle of a split access at the highest odd address wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address |
| req_word | input | 1 | 1 = word (16-bit) access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 2*BYTE_W | Write data (bits 7:0 for byte writes) |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 2*BYTE_W | Read result |
| bus_cyc | output | 1 | Bus cycle active this clock |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_a0 | output | 1 | A0 line; low enables the low lane |
| bus_bhe_n | output | 1 | Active-low high-lane enable |
| bus_wdata | output | 2*BYTE_W | Bus write data, both lanes |
| bus_rdata | input | 2*BYTE_W | Bus read data, sampled at the end of the cycle |

## Verification
The bench sweeps every byte address of a 64-byte space with byte writes, byte reads, and word writes each followed by a word read. After each word write it also reads the two neighbouring bytes, so a misaligned write that enabled the wrong lane shows up as a corrupted neighbour. A swapped merge at an odd word read returns the two bytes in reverse order. A wrong lane pick on byte reads returns the other byte of the word, or non-zero upper bits. The highest odd address makes a controller that fails to wrap go out of range. Latency checks on every request catch a missing or extra split cycle.

// File: rtl/blc_pkg.sv
package blc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } blc_state_e;

    typedef struct packed {
        logic a0;
        logic bhe_n;
    } lane_sel_t;

    // low lane on, high lane off
    localparam lane_sel_t LANE_LO   = '{a0: 1'b0, bhe_n: 1'b1};
    // low lane off, high lane on
    localparam lane_sel_t LANE_HI   = '{a0: 1'b1, bhe_n: 1'b0};
    // both lanes on
    localparam lane_sel_t LANE_BOTH = '{a0: 1'b0, bhe_n: 1'b0};

endpackage

// File: rtl/blc_seq.sv
module blc_seq
    import blc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              cyc,
    output logic              phase2,
    output logic              split,
    output logic              last,
    output logic              done,
    output logic [ADDR_W-1:0] addr,
    output logic              word,
    output logic              write,
    output logic [DATA_W-1:0] wdata
);

    typedef struct packed {
        blc_state_e        st;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic              word;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } seq_t;

    seq_t seq_d, seq_q;
    logic split_w;

    assign split_w = seq_q.word & seq_q.addr[0];

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.addr  = req_addr;
                    seq_d.word  = req_word;
                    seq_d.write = req_write;
                    seq_d.wdata = req_wdata;
                    seq_d.st    = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (split_w) begin
                    seq_d.st = ST_SECOND;
                end else begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            ST_SECOND: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == ST_IDLE);
    assign cyc       = (seq_q.st != ST_IDLE);
    assign phase2    = (seq_q.st == ST_SECOND);
    assign split     = split_w;
    assign last      = (seq_q.st == ST_SECOND) || ((seq_q.st == ST_FIRST) && !split_w);
    assign done      = seq_q.done;
    assign addr      = seq_q.addr;
    assign word      = seq_q.word;
    assign write     = seq_q.write;
    assign wdata     = seq_q.wdata;

    // R6
    second_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_SECOND) |-> $past(seq_q.st == ST_FIRST));

endmodule

// File: rtl/blc_lane_gen.sv
module blc_lane_gen
    import blc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int DATA_W = 2 * BYTE_W
) (
    input  logic              cyc,
    input  logic              phase2,
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    input  logic              write,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_a0,
    output logic              bus_bhe_n,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata
);

    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] next_addr;
    logic              odd;
    lane_sel_t         sel;

    assign odd       = addr[0];
    assign base_addr = {addr[ADDR_W-1:1], 1'b0};
    assign next_addr = base_addr + WORD_STEP;

    always_comb begin
        bus_addr  = base_addr;
        sel       = LANE_LO;
        bus_wdata = {2{wdata[BYTE_W-1:0]}};
        if (!word) begin
            sel = odd ? LANE_HI : LANE_LO;
        end else if (!odd) begin
            sel       = LANE_BOTH;
            bus_wdata = wdata;
        end else if (!phase2) begin
            sel = write ? LANE_HI : LANE_BOTH;
        end else begin
            bus_addr  = next_addr;
            sel       = write ? LANE_LO : LANE_BOTH;
            bus_wdata = {2{wdata[DATA_W-1:BYTE_W]}};
        end
        if (!cyc) begin
            bus_addr = '0;
            sel      = LANE_LO;
        end
    end

    assign bus_a0    = sel.a0;
    assign bus_bhe_n = sel.bhe_n;
    assign bus_we    = cyc & write;

endmodule

// File: rtl/blc_read_merge.sv
module blc_read_merge #(
    parameter int BYTE_W = 8,
    parameter int DATA_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc,
    input  logic              phase2,
    input  logic              split,
    input  logic              last,
    input  logic              word,
    input  logic              write,
    input  logic              odd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        logic [DATA_W-1:0] result;
    } mrg_t;

    mrg_t mrg_d, mrg_q;
    logic [BYTE_W-1:0] lo_lane, hi_lane;

    assign lo_lane = bus_rdata[BYTE_W-1:0];
    assign hi_lane = bus_rdata[DATA_W-1:BYTE_W];

    always_comb begin
        mrg_d = mrg_q;
        if (cyc && !write && split && !phase2) begin
            mrg_d.hold = hi_lane;
        end
        if (cyc && !write && last) begin
            if (!word) begin
                mrg_d.result = {{BYTE_W{1'b0}}, (odd ? hi_lane : lo_lane)};
            end else if (split) begin
                mrg_d.result = {lo_lane, mrg_q.hold};
            end else begin
                mrg_d.result = bus_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrg_q <= '0;
        end else begin
            mrg_q <= mrg_d;
        end
    end

    assign rsp_rdata = mrg_q.result;

endmodule

// File: rtl/bytelane_bus_ctrl.sv
module bytelane_bus_ctrl
    import blc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    localparam int DATA_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_a0,
    output logic              bus_bhe_n,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic              phase2, split, last;
    logic [ADDR_W-1:0] addr_q;
    logic              word_q, write_q;
    logic [DATA_W-1:0] wdata_q;

    blc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_word (req_word),
        .req_write(req_write),
        .req_wdata(req_wdata),
        .req_ready(req_ready),
        .cyc      (bus_cyc),
        .phase2   (phase2),
        .split    (split),
        .last     (last),
        .done     (rsp_done),
        .addr     (addr_q),
        .word     (word_q),
        .write    (write_q),
        .wdata    (wdata_q)
    );

    blc_lane_gen #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)) i_lane (
        .cyc      (bus_cyc),
        .phase2   (phase2),
        .addr     (addr_q),
        .word     (word_q),
        .write    (write_q),
        .wdata    (wdata_q),
        .bus_addr (bus_addr),
        .bus_a0   (bus_a0),
        .bus_bhe_n(bus_bhe_n),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata)
    );

    blc_read_merge #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) i_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (bus_cyc),
        .phase2   (phase2),
        .split    (split),
        .last     (last),
        .word     (word_q),
        .write    (write_q),
        .odd      (addr_q[0]),
        .bus_rdata(bus_rdata),
        .rsp_rdata(rsp_rdata)
    );

    // R5
    no_a0_without_bhe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !(bus_a0 && bus_bhe_n));

    // R9
    ready_low_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !req_ready);

    // R9
    accept_starts_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_cyc);

    // R9
    done_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ($past(bus_cyc) && !bus_cyc));

    // R9
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R11
    split_step_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc)) |-> (bus_addr == ADDR_W'($past(bus_addr) + 2)));

    // R8
    split_write_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc) && bus_we) |->
        (!bus_a0 && bus_bhe_n && $past(bus_a0) && !$past(bus_bhe_n)));

    // R1
    aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !bus_addr[0]);

endmodule

// File: tb/test_bytelane_bus_ctrl.sv
module test_ram16 #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          cyc,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          a0,
    input  logic          bhe_n,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata
);
    localparam int NW = 2 ** (AW - 1);
    logic [15:0] mem [NW];

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = '0;
    end

    assign rdata = mem[addr[AW-1:1]];

    always @(posedge clk) begin
        if (cyc && we) begin
            if (!a0)    mem[addr[AW-1:1]][7:0]  <= wdata[7:0];
            if (!bhe_n) mem[addr[AW-1:1]][15:8] <= wdata[15:8];
        end
    end
endmodule

module test_bytelane_bus_ctrl;
    localparam int AW = 6;
    localparam int NB = 2 ** AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_word = 1'b0;
    logic          req_write = 1'b0;
    logic [15:0]   req_wdata = '0;
    logic          rsp_done;
    logic [15:0]   rsp_rdata;
    logic          bus_cyc, bus_we, bus_a0, bus_bhe_n;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata, bus_rdata;

    always #2 clk = ~clk;

    bytelane_bus_ctrl #(.ADDR_W(AW), .BYTE_W(8)) i_bytelane_bus_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_a0(bus_a0), .bus_bhe_n(bus_bhe_n),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    test_ram16 #(.AW(AW)) i_ram (
        .clk(clk), .cyc(bus_cyc), .we(bus_we), .addr(bus_addr),
        .a0(bus_a0), .bhe_n(bus_bhe_n), .wdata(bus_wdata), .rdata(bus_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] ref_mem [NB];

    int          mon_n = 0;
    logic [AW-1:0] mon_addr [4];
    logic        mon_a0 [4];
    logic        mon_bhe [4];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus monitor, sampled away from the rising edge
    always @(negedge clk) begin
        if (rst_n && bus_cyc) begin
            chk(!req_ready, "R9 ready low during bus cycle", {31'd0, req_ready}, 32'd0);
            if (mon_n < 4) begin
                mon_addr[mon_n] = bus_addr;
                mon_a0[mon_n]   = bus_a0;
                mon_bhe[mon_n]  = bus_bhe_n;
            end
            mon_n = mon_n + 1;
        end
    end

    task automatic do_req(input int a, input bit w, input bit we, input logic [15:0] wd,
                          output logic [15:0] rd);
        int exp_n, lat;
        bit got;
        logic [AW-1:0] e_addr [2];
        logic e_a0 [2];
        logic e_bhe [2];
        string tg;
        exp_n = (w && a[0]) ? 2 : 1;
        e_addr[0] = AW'(a & ~1);
        e_addr[1] = AW'(a + 1);
        if (!w) begin
            e_a0[0] = a[0]; e_bhe[0] = !a[0];
            tg = a[0] ? "R3 byte odd lanes" : "R2 byte even lanes";
        end else if (!a[0]) begin
            e_a0[0] = 1'b0; e_bhe[0] = 1'b0;
            tg = "R4 word even lanes";
        end else if (we) begin
            e_a0[0] = 1'b1; e_bhe[0] = 1'b0; e_a0[1] = 1'b0; e_bhe[1] = 1'b1;
            tg = (a == NB - 1) ? "R11 split write wrap" : "R8 split write lanes";
        end else begin
            e_a0[0] = 1'b0; e_bhe[0] = 1'b0; e_a0[1] = 1'b0; e_bhe[1] = 1'b0;
            tg = (a == NB - 1) ? "R11 split read wrap" : "R6 split read lanes";
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        mon_n = 0;
        req_valid = 1'b1; req_addr = AW'(a); req_word = w; req_write = we; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; lat = 0; rd = '0;
        for (int k = 0; k < 6; k++) begin
            if (!got) begin
                if (rsp_done) begin
                    got = 1; lat = k; rd = rsp_rdata;
                end else begin
                    @(negedge clk);
                end
            end
        end
        chk(got && lat == exp_n, "R9 done latency", 32'(lat), 32'(exp_n));
        chk(mon_n == exp_n, "R6 bus cycle count", 32'(mon_n), 32'(exp_n));
        for (int c = 0; c < exp_n; c++) begin
            chk(mon_addr[c] == e_addr[c], {tg, " addr"}, 32'(mon_addr[c]), 32'(e_addr[c]));
            chk(mon_a0[c] == e_a0[c] && mon_bhe[c] == e_bhe[c], {tg, " a0/bhe_n"},
                {30'd0, mon_a0[c], mon_bhe[c]}, {30'd0, e_a0[c], e_bhe[c]});
            chk(!(mon_a0[c] && mon_bhe[c]), "R5 illegal lane pair", 32'd0, 32'd0);
        end
        @(negedge clk);
        chk(!rsp_done && req_ready, "R9 done single pulse",
            {30'd0, rsp_done, req_ready}, 32'd1);
    endtask

    task automatic wr_byte(input int a, input logic [7:0] v);
        logic [15:0] rd;
        do_req(a, 1'b0, 1'b1, {8'h00, v}, rd);
        ref_mem[a] = v;
    endtask

    task automatic rd_byte(input int a, input string tg);
        logic [15:0] rd;
        do_req(a, 1'b0, 1'b0, 16'h0, rd);
        chk(rd == {8'h00, ref_mem[a]}, tg, 32'(rd), {24'd0, ref_mem[a]});
    endtask

    initial begin
        logic [15:0] rd;
        logic [15:0] wd, ex;
        for (int i = 0; i < NB; i++) ref_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_done && !bus_cyc, "R9 reset state",
            {29'd0, req_ready, rsp_done, bus_cyc}, 32'd4);

        // byte writes over the whole space, then byte reads (R1 R2 R3 R7)
        for (int a = 0; a < NB; a++) wr_byte(a, 8'((a * 29 + 7) & 8'hff));
        for (int a = 0; a < NB; a++) rd_byte(a, "R7 byte read zero-extended lane");

        // word write then word read at every address (R4 R6 R8 R10 R11)
        for (int a = 0; a < NB; a++) begin
            wd = 16'((a * 613 + 16'h1234) & 16'hffff);
            do_req(a, 1'b1, 1'b1, wd, rd);
            ref_mem[a] = wd[7:0];
            ref_mem[(a + 1) % NB] = wd[15:8];
            do_req(a, 1'b1, 1'b0, 16'h0, rd);
            ex = {ref_mem[(a + 1) % NB], ref_mem[a]};
            chk(rd == ex, "R10 word read little-endian", 32'(rd), 32'(ex));
            rd_byte(a, "R10 low byte at lower address");
            rd_byte((a + NB - 1) % NB, "R8 neighbour below untouched");
            rd_byte((a + 2) % NB, "R8 neighbour above untouched");
        end

        // even-word read against byte view (R1)
        for (int a = 0; a < NB; a += 2) begin
            do_req(a, 1'b1, 1'b0, 16'h0, rd);
            ex = {ref_mem[a + 1], ref_mem[a]};
            chk(rd == ex, "R1 lane mapping even word", 32'(rd), 32'(ex));
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule